// File: doc/BRIEF.md
# Bit-Granular Lane Striping Permuter

This block reorders a group of N bytes, one byte per parallel flash lane, so that a serial bit stream is dealt out across the lanes one bit at a time instead of one whole byte per lane. It sits between a byte-oriented data path and N memory devices that are read or written side by side. Bits enter the stream least significant bit first, starting with byte 0. They are dealt round-robin to the lanes, and each lane's byte fills from its least significant bit upward.

A direction input picks the forward (stripe) or the inverse (unstripe) mapping, so the same unit serves both the write and the read path. Data moves through a single output register. A valid/ready handshake sits on each side, with one cycle of latency, and a new group is accepted in the same cycle the previous one is drained. The lane count N is a parameter from 1 to 4.

Top module: `bit_striper`

## Requirements
- R1: With dir_inv = 0, input bit b of input byte i (flat bit 8*i+b of in_data) is stream position s = 8*i+b and appears at output byte s mod N, bit s div N (flat bit 8*(s mod N) + s div N of out_data). Every output bit comes from exactly one input bit.
- R2: With dir_inv = 1, output flat bit s = 8*i+b takes input flat bit 8*(s mod N) + s div N, which is the exact inverse of R1.
- R3: Sending a group forward and then sending the result back with dir_inv = 1 returns the original group.
- R4: With N = 3 in the forward direction, in_data = 0x249249 (byte 0 = 0x49, byte 1 = 0x92, byte 2 = 0x24) gives out_data = 0x0000FF. Output byte 0 is filled by input byte 0 bits 0,3,6, then input byte 1 bits 1,4,7, then input byte 2 bits 2,5.
- R5: With N = 1 both directions pass the byte through unchanged.
- R6: out_data and out_valid load only on a cycle where in_valid and in_ready are both high. The transformed group is on out_data with out_valid high in the cycle after that edge.
- R7: While out_valid is high and out_ready is low, out_valid stays high, out_data holds, and in_ready is low, so a waiting input is not taken.
- R8: A synchronous active-high rst clears out_valid and out_data to zero.
- R9: When out_valid and out_ready are both high, in_ready is high. A group presented in that cycle replaces the drained one with no idle cycle. If no group is presented, out_valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_inv | input | 1 | 0 = stripe (forward), 1 = unstripe (inverse); sampled with the input group |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block can take an input group this cycle |
| in_data | input | 8*LANES | Input group, byte i at bits 8*i+7 down to 8*i |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Consumer takes the output group this cycle |
| out_data | output | 8*LANES | Permuted group, byte layout as in_data |

## Verification
Two events can land in the same clock edge: the consumer draining the held group and the producer loading a new one. A change of direction between consecutive groups can also fall on that edge. The bench provokes both by toggling out_ready at random while groups of random data and random direction are offered back to back. It also holds out_ready low across several offers to force the stall case. A behavioural model of the handshake and of the bit mapping, built from the stream-position formula, predicts out_valid, in_ready and out_data for N = 1, 2 and 3 on every clock. Any disagreement, including a dropped or duplicated group at a drain-and-load edge, is flagged.

// File: rtl/bit_striper.sv
module bit_striper #(
  parameter int LANES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dir_inv,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*LANES-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*LANES-1:0] out_data
);
  localparam int W = 8 * LANES;

  logic [W-1:0] fwd_bits;
  logic [W-1:0] inv_bits;
  logic         take;

  // stream position s maps to lane s%LANES, bit s/LANES
  for (genvar s = 0; s < W; s++) begin : g_map
    localparam int DST = 8 * (s % LANES) + (s / LANES);
    assign fwd_bits[DST] = in_data[s];
    assign inv_bits[s]   = in_data[DST];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= dir_inv ? inv_bits : fwd_bits;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_striper_chk.sv
module bit_striper_chk #(
  parameter int LANES = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [8*LANES-1:0] in_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic [8*LANES-1:0] out_data
);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  ones_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ($countones(out_data) == $countones($past(in_data))));

  // R9
  drain_open_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> in_ready);
endmodule

bind bit_striper bit_striper_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/bit_striper_bench.sv
`timescale 1ns/1ps
module bit_striper_bench;
  logic clk = 0;
  logic rst = 1;
  logic dir_inv = 0;
  logic in_valid = 0;
  logic out_ready = 1;
  logic [7:0]  d1 = '0;
  logic [15:0] d2 = '0;
  logic [23:0] d3 = '0;
  logic r1, r2, r3;
  logic v1, v2, v3;
  logic [7:0]  o1;
  logic [15:0] o2;
  logic [23:0] o3;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit rand_ready = 0;

  always #5 clk = ~clk;

  bit_striper #(.LANES(1)) u_bit_striper_1 (.clk(clk), .rst(rst), .dir_inv(dir_inv),
    .in_valid(in_valid), .in_ready(r1), .in_data(d1), .out_valid(v1),
    .out_ready(out_ready), .out_data(o1));
  bit_striper #(.LANES(2)) u_bit_striper_2 (.clk(clk), .rst(rst), .dir_inv(dir_inv),
    .in_valid(in_valid), .in_ready(r2), .in_data(d2), .out_valid(v2),
    .out_ready(out_ready), .out_data(o2));
  bit_striper #(.LANES(3)) u_bit_striper (.clk(clk), .rst(rst), .dir_inv(dir_inv),
    .in_valid(in_valid), .in_ready(r3), .in_data(d3), .out_valid(v3),
    .out_ready(out_ready), .out_data(o3));

  function automatic logic [31:0] perm(int n, bit inv, logic [31:0] x);
    logic [31:0] r = '0;
    for (int s = 0; s < 8 * n; s++) begin
      int d = 8 * (s % n) + s / n;
      if (!inv) r[d] = x[s];
      else      r[s] = x[d];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model of handshake and mapping
  logic        m_val = 0;
  logic        m_dir = 0;
  logic [31:0] m1 = 0, m2 = 0, m3 = 0;
  wire m_rdy = !m_val || out_ready;

  always @(posedge clk) begin
    if (rst) begin
      m_val <= 0; m1 <= 0; m2 <= 0; m3 <= 0;
    end else if (in_valid && m_rdy) begin
      m_val <= 1; m_dir <= dir_inv;
      m1 <= perm(1, dir_inv, {24'b0, d1});
      m2 <= perm(2, dir_inv, {16'b0, d2});
      m3 <= perm(3, dir_inv, {8'b0, d3});
    end else if (out_ready) begin
      m_val <= 0;
    end
  end

  always begin
    @(negedge clk); #2;
    if (!rst && !done) begin
      check(v1 == m_val && v2 == m_val && v3 == m_val, "R6/R7/R9 out_valid",
            {29'b0, v3, v2, v1}, {29'b0, m_val, m_val, m_val});
      check(r1 == m_rdy && r2 == m_rdy && r3 == m_rdy, "R7/R9 in_ready",
            {29'b0, r3, r2, r1}, {29'b0, m_rdy, m_rdy, m_rdy});
      if (m_val) begin
        check(o1 == m1[7:0], "R5 lane1 data", {24'b0, o1}, m1);
        check(o2 == m2[15:0], m_dir ? "R2 lane2 data" : "R1 lane2 data", {16'b0, o2}, m2);
        check(o3 == m3[23:0], m_dir ? "R2 lane3 data" : "R1 lane3 data", {8'b0, o3}, m3);
      end
    end
  end

  always begin
    @(negedge clk);
    if (rand_ready) out_ready = ($urandom_range(0, 3) != 0);
  end

  // present a group at the current negedge, return at the negedge after it is taken
  task automatic send(bit dir, logic [7:0] a, logic [15:0] b, logic [23:0] c);
    dir_inv = dir; d1 = a; d2 = b; d3 = c; in_valid = 1;
    #1;
    while (!r3) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(1_500_000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] x3, y3;
    logic [15:0] x2, y2;
    logic [7:0]  x1;
    repeat (3) @(negedge clk);
    #2;
    // R8 reset state
    check(!v1 && !v2 && !v3 && o1 == 0 && o2 == 0 && o3 == 0, "R8 reset",
          {5'b0, v3, v2, v1, o3}, 32'h0);
    @(negedge clk);
    rst = 0;

    // R4 example for three lanes
    send(0, 8'h5A, 16'h0001, 24'h249249);
    in_valid = 0;
    #1;
    check(o3 == 24'h0000FF, "R4 three-lane example", {8'b0, o3}, 32'hFF);
    check(o1 == 8'h5A, "R5 single-lane forward", {24'b0, o1}, 32'h5A);
    check(o2 == 16'h0001, "R1 two-lane bit0", {16'b0, o2}, 32'h1);

    // R3 round trip on random groups
    for (int k = 0; k < 20; k++) begin
      x1 = $urandom; x2 = $urandom; x3 = $urandom;
      @(negedge clk);
      send(0, x1, x2, x3);
      in_valid = 0;
      #1; y2 = o2; y3 = o3;
      @(negedge clk);
      send(1, o1, y2, y3);
      in_valid = 0;
      #1;
      check(o3 == x3, "R3 round trip N=3", {8'b0, o3}, {8'b0, x3});
      check(o2 == x2, "R3 round trip N=2", {16'b0, o2}, {16'b0, x2});
      check(o1 == x1, "R5 single-lane round trip", {24'b0, o1}, {24'b0, x1});
    end

    // R7 stall: output held, waiting input not taken
    @(negedge clk);
    out_ready = 0;
    send(0, 8'h11, 16'h2233, 24'h445566);
    x3 = o3;
    dir_inv = 1; d3 = 24'hABCDEF; d2 = 16'h9999; d1 = 8'h77; in_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    check(o3 == x3 && v3 && !r3, "R7 held while stalled", {8'b0, o3}, {8'b0, x3});
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    #1;
    check(o3 == perm(3, 1, 24'hABCDEF), "R6/R9 waiting group loads on drain",
          {8'b0, o3}, perm(3, 1, 24'hABCDEF));
    @(negedge clk);
    #1;
    check(!v3, "R9 out_valid falls when idle", {31'b0, v3}, 32'h0);

    // random traffic with back-to-back groups and random draining
    rand_ready = 1;
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 4) == 0) begin
        in_valid = 0;
        @(negedge clk);
      end else begin
        send($urandom_range(0, 1), $urandom, $urandom, $urandom);
      end
    end
    in_valid = 0;
    rand_ready = 0;
    out_ready = 1;
    repeat (3) @(negedge clk);

    // R8 reset in mid-traffic
    send(0, 8'hFF, 16'hFFFF, 24'hFFFFFF);
    rst = 1; in_valid = 0;
    @(negedge clk);
    #2;
    check(!v3 && o3 == 0 && o2 == 0 && o1 == 0, "R8 reset clears output",
          {7'b0, v3, o3}, 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule